// File: doc/BRIEF.md
# Millisecond Periodic Interval Timer

This block produces a periodic interrupt whose period is a whole number of milliseconds. A prescaler divides the system clock down to a 1 ms tick; the number of system clock cycles per millisecond is a parameter. Software programs a 32-bit reload value, and the period becomes reload+1 milliseconds. The interrupt is a level. When a period ends, the interrupt goes high and the next period starts at once, with no help from software.

Software clears the interrupt in one of two ways. It can read the count register, which always returns zero. Or it can write a new reload value, which also restarts the period from that write. After reset the timer is idle: nothing counts and no interrupt is raised until the reload register is first written. Access is through a simple single-cycle register port. Writes take effect on the clock edge at which they are sampled. Read data is combinational from the current state.

Top module: `ms_interval_timer`

## Requirements
- R1: After reset the interrupt is low and a read of the reload register (byte offset 0x228) returns 0.
- R2: After reset, and until the reload register is first written, the interrupt stays low however long the clock runs.
- R3: With reload value R written at clock edge E, the interrupt goes high after edge E + CLKS_PER_MS*(R+1) and is low before it.
- R4: On expiry a new period of the same length starts immediately, and the interrupt stays high until it is acknowledged.
- R5: A read of the count register (byte offset 0x230) returns 0 and lowers the interrupt at the sampling edge.
- R6: A write of the reload register lowers the interrupt at the sampling edge and restarts the period from that edge.
- R7: A read of the reload register returns the full 32-bit value last written to it.
- R8: When an expiry and a count read fall on the same edge, the interrupt ends up high.
- R9: A reload of 0xFFFFFFFF is kept intact: it reads back unchanged, and the period counter never passes the reload value, so the counter does not wrap.
- R10: Writes to other offsets change neither the reload value nor the interrupt. Reads of other offsets return 0 and do not lower the interrupt.
- R11: A write to the count register offset does not lower the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits [1:0] are ignored |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational |
| irq_o | output | 1 | Level interrupt |

## Verification
A wrong prescaler or period counter shows up as an interrupt edge that comes early or late. A per-cycle reference model catches this on the very edge where the RTL and the model first disagree, which is at most one period after the fault. A wrong reload register shows up at once on a readback, and later as a wrong period. Faulty clear priority (expiry against acknowledge, reprogram against expiry) is driven onto a single edge, so the interrupt level one cycle later exposes it.

// File: rtl/tmr_pkg.sv
// Package: shared register offsets and access kinds for the interval timer.
// Assumes byte addressing with 32-bit word registers.
package tmr_pkg;
    localparam logic [13:0] TMR_RELOAD_OFS = 14'h228;
    localparam logic [13:0] TMR_COUNT_OFS  = 14'h230;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_ACK   = 2'd2,
        ACC_OTHER = 2'd3
    } tmr_access_e;
endpackage

// File: rtl/tmr_regs.sv
// Register front end: decodes accesses, holds the reload value and the
// armed flag, and produces one-cycle restart and acknowledge strobes.
// Assumes a single-cycle access protocol with word-aligned decoding.
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] reload_q,
    output logic              armed_q,
    output logic              restart,
    output logic              ack
);
    localparam int WORD_W = ADDR_W - 2;
    localparam logic [WORD_W-1:0] LOAD_WORD  = WORD_W'(TMR_RELOAD_OFS >> 2);
    localparam logic [WORD_W-1:0] COUNT_WORD = WORD_W'(TMR_COUNT_OFS >> 2);

    logic [WORD_W-1:0] word_idx;
    tmr_access_e       acc;
    logic              unused_lanes;

    assign word_idx     = bus_addr[ADDR_W-1:2];
    assign unused_lanes = ^bus_addr[1:0];

    // Classify the current access by target and direction.
    always_comb begin
        acc = ACC_NONE;
        if (bus_sel) begin
            if (bus_wr && word_idx == LOAD_WORD)        acc = ACC_LOAD;
            else if (!bus_wr && word_idx == COUNT_WORD) acc = ACC_ACK;
            else                                        acc = ACC_OTHER;
        end
    end

    assign restart = (acc == ACC_LOAD);
    assign ack     = (acc == ACC_ACK);

    // Hold the reload value and arm the timer on its first write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
            armed_q  <= 1'b0;
        end else if (restart) begin
            reload_q <= bus_wdata;
            armed_q  <= 1'b1;
        end
    end

    // Return the reload value on its own read; everything else reads zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr && word_idx == LOAD_WORD)
            bus_rdata = reload_q;
    end
endmodule

// File: rtl/tmr_prescaler.sv
// Prescaler: emits a one-cycle tick every CLKS_PER_MS cycles while armed.
// Assumes restart aligns the phase so that the first tick comes a full
// millisecond after the restart edge.
module tmr_prescaler #(
    parameter int CLKS_PER_MS = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic restart,
    output logic tick
);
    generate
        if (CLKS_PER_MS <= 1) begin : g_pass
            logic unused_ps;
            assign unused_ps = clk ^ rst_n ^ restart;
            assign tick      = armed;
        end else begin : g_div
            localparam int PS_W = $clog2(CLKS_PER_MS);
            localparam logic [PS_W-1:0] PS_LAST = PS_W'(CLKS_PER_MS - 1);
            logic [PS_W-1:0] ps_cnt;

            assign tick = armed && (ps_cnt == PS_LAST);

            // Count cycles within the current millisecond.
            always_ff @(posedge clk) begin
                if (!rst_n || restart) ps_cnt <= '0;
                else if (tick)         ps_cnt <= '0;
                else if (armed)        ps_cnt <= ps_cnt + PS_W'(1);
            end
        end
    endgenerate
endmodule

// File: rtl/tmr_period.sv
// Period counter: counts millisecond ticks and flags the tick that closes a
// period of reload+1 ms. Assumes the counter is one bit wider than the
// reload, so that reload+1 cannot overflow.
module tmr_period #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              tick,
    input  logic [DATA_W-1:0] reload,
    output logic              expire,
    output logic [DATA_W:0]   ms_cnt
);
    localparam int PW = DATA_W + 1;

    logic [PW-1:0] ms_next;
    logic [PW-1:0] target;

    assign ms_next = ms_cnt + PW'(1);
    assign target  = {1'b0, reload} + PW'(1);
    assign expire  = tick && (ms_next == target);

    // Advance the millisecond count and wrap at the end of each period.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) ms_cnt <= '0;
        else if (expire)       ms_cnt <= '0;
        else if (tick)         ms_cnt <= ms_next;
    end
endmodule

// File: rtl/ms_interval_timer.sv
// Top level: a programmable millisecond periodic timer with a level
// interrupt. Priority on one edge: a reprogram clears, otherwise an expiry
// sets, otherwise an acknowledge clears.
module ms_interval_timer #(
    parameter int ADDR_W      = 14,
    parameter int DATA_W      = 32,
    parameter int CLKS_PER_MS = 50000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);
    logic [DATA_W-1:0] reload_q;
    logic              armed_q;
    logic              restart;
    logic              ack;
    logic              tick;
    logic              expire;
    logic [DATA_W:0]   ms_cnt;

    tmr_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .reload_q  (reload_q),
        .armed_q   (armed_q),
        .restart   (restart),
        .ack       (ack)
    );

    tmr_prescaler #(.CLKS_PER_MS(CLKS_PER_MS)) i_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .armed   (armed_q),
        .restart (restart),
        .tick    (tick)
    );

    tmr_period #(.DATA_W(DATA_W)) i_period (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .tick    (tick),
        .reload  (reload_q),
        .expire  (expire),
        .ms_cnt  (ms_cnt)
    );

    // Interrupt level: reprogram clears, expiry sets, acknowledge clears.
    always_ff @(posedge clk) begin
        if (!rst_n)       irq_o <= 1'b0;
        else if (restart) irq_o <= 1'b0;
        else if (expire)  irq_o <= 1'b1;
        else if (ack)     irq_o <= 1'b0;
    end
endmodule

// File: rtl/ms_interval_timer_chk.sv
// Checker: temporal properties of the interval timer, bound to the top.
// Assumes the internal strobes named in the bind below.
module ms_interval_timer_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              restart,
    input logic              ack,
    input logic              expire,
    input logic              armed_q,
    input logic              irq_o,
    input logic [DATA_W:0]   ms_cnt,
    input logic [DATA_W-1:0] reload_q,
    input logic [DATA_W-1:0] bus_rdata
);
    // R2: no interrupt while not yet armed.
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_q |-> !irq_o);

    // R3: the interrupt only rises after an expiry.
    p_rise_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(expire));

    // R4: an expiry without a reprogram leaves the interrupt high.
    p_expire_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !restart) |=> irq_o);

    // R5: an acknowledge with no expiry lowers the interrupt.
    p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !expire && !restart) |=> !irq_o);

    // R5: count reads return zero.
    p_ack_reads_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (bus_rdata == '0));

    // R6: a reprogram lowers the interrupt.
    p_restart_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !irq_o);

    // R8: expiry wins over an acknowledge on the same edge.
    p_expire_beats_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && ack && !restart) |=> irq_o);

    // R9: the period counter never passes the reload value.
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ms_cnt <= {1'b0, reload_q});
endmodule

bind ms_interval_timer ms_interval_timer_chk #(.DATA_W(DATA_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .ack       (ack),
    .expire    (expire),
    .armed_q   (armed_q),
    .irq_o     (irq_o),
    .ms_cnt    (ms_cnt),
    .reload_q  (reload_q),
    .bus_rdata (bus_rdata)
);

// File: tb/test_ms_interval_timer.sv
// Bench: drives register accesses and compares irq_o and bus_rdata against a
// behavioural cycle model on every clock, plus directed checks.
module test_ms_interval_timer;
    localparam int ADDR_W = 14;
    localparam int DATA_W = 32;
    localparam int CPM    = 4;
    localparam logic [13:0] A_LOAD  = 14'h228;
    localparam logic [13:0] A_COUNT = 14'h230;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              irq_o;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    bit    started = 0;
    string focus = "R1";

    // Behavioural model state.
    longint m_reload = 0;
    longint m_elapsed = 0;
    bit     m_armed = 0;
    bit     m_irq = 0;

    always #10 clk = ~clk;

    ms_interval_timer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLKS_PER_MS(CPM)) i_ms_interval_timer (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Model update at each rising edge, from the requirements.
    always @(posedge clk) begin
        bit hit;
        if (!rst_n) begin
            m_reload = 0; m_armed = 0; m_elapsed = 0; m_irq = 0;
        end else if (bus_sel && bus_wr && bus_addr[13:2] == A_LOAD[13:2]) begin
            m_reload = longint'(bus_wdata); m_armed = 1; m_elapsed = 0; m_irq = 0;
        end else begin
            hit = 0;
            if (m_armed) begin
                m_elapsed++;
                if (m_elapsed == longint'(CPM) * (m_reload + 1)) begin
                    hit = 1; m_elapsed = 0;
                end
            end
            if (hit) m_irq = 1;
            else if (bus_sel && !bus_wr && bus_addr[13:2] == A_COUNT[13:2]) m_irq = 0;
        end
        started = 1;
    end

    // Per-cycle comparison away from the edge, plus watchdog.
    always @(negedge clk) begin
        logic [31:0] exp_rd;
        cycles++;
        if (started) begin
            exp_rd = (bus_sel && !bus_wr && bus_addr[13:2] == A_LOAD[13:2]) ? 32'(m_reload) : 32'h0;
            chk(irq_o == m_irq, focus, "irq vs model", 32'(irq_o), 32'(m_irq));
            chk(bus_rdata == exp_rd, focus, "rdata vs model", bus_rdata, exp_rd);
        end
        if (cycles > 100000) begin
            chk(1'b0, focus, "watchdog expired", 32'(cycles), 32'd0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [13:0] a, input logic [31:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #2;
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [13:0] a, output logic [31:0] d);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        @(negedge clk); d = bus_rdata;
        @(posedge clk); #2;
        bus_sel = 0;
    endtask

    initial begin
        logic [31:0] v;
        idle(3);
        rst_n = 1;
        focus = "R1";
        chk(irq_o == 0, "R1", "irq after reset", 32'(irq_o), 0);
        rd(A_LOAD, v);
        chk(v == 0, "R1", "reload after reset", v, 0);

        focus = "R2";
        idle(50);
        chk(irq_o == 0, "R2", "irq while unarmed", 32'(irq_o), 0);

        focus = "R3";
        wr(A_LOAD, 32'd2);
        idle(11);
        chk(irq_o == 0, "R3", "irq one cycle before expiry", 32'(irq_o), 0);
        idle(1);
        chk(irq_o == 1, "R3", "irq at expiry", 32'(irq_o), 1);

        focus = "R4";
        idle(12);
        chk(irq_o == 1, "R4", "irq held without ack", 32'(irq_o), 1);
        focus = "R5";
        rd(A_COUNT, v);
        chk(v == 0, "R5", "count reads zero", v, 0);
        chk(irq_o == 0, "R5", "irq after count read", 32'(irq_o), 0);
        focus = "R4";
        idle(10);
        chk(irq_o == 0, "R4", "irq before next period ends", 32'(irq_o), 0);
        idle(1);
        chk(irq_o == 1, "R4", "auto restart expiry", 32'(irq_o), 1);

        focus = "R6";
        wr(A_LOAD, 32'd1);
        chk(irq_o == 0, "R6", "irq after reprogram", 32'(irq_o), 0);
        idle(7);
        chk(irq_o == 0, "R6", "restarted period not over", 32'(irq_o), 0);
        idle(1);
        chk(irq_o == 1, "R6", "restarted period expiry", 32'(irq_o), 1);

        focus = "R11";
        wr(A_COUNT, 32'h0);
        chk(irq_o == 1, "R11", "write to count offset keeps irq", 32'(irq_o), 1);

        focus = "R10";
        wr(14'h220, 32'h55);
        wr(14'h22C, 32'h77);
        rd(A_LOAD, v);
        chk(v == 1, "R10", "reload after stray writes", v, 1);
        rd(14'h210, v);
        chk(v == 0, "R10", "other offset reads zero", v, 0);
        chk(irq_o == 1, "R10", "irq kept after other accesses", 32'(irq_o), 1);

        focus = "R7";
        wr(A_LOAD, 32'h8D3E_19C7);
        rd(A_LOAD, v);
        chk(v == 32'h8D3E_19C7, "R7", "reload readback", v, 32'h8D3E_19C7);

        focus = "R8";
        wr(A_LOAD, 32'd0);
        idle(3);
        rd(A_COUNT, v);
        chk(irq_o == 1, "R8", "expiry beats same-edge ack", 32'(irq_o), 1);
        rd(A_COUNT, v);
        chk(irq_o == 0, "R5", "ack after collision", 32'(irq_o), 0);

        focus = "R9";
        wr(A_LOAD, 32'hFFFF_FFFF);
        idle(300);
        chk(irq_o == 0, "R9", "no early expiry at max reload", 32'(irq_o), 0);
        rd(A_LOAD, v);
        chk(v == 32'hFFFF_FFFF, "R9", "max reload readback", v, 32'hFFFF_FFFF);

        idle(2);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule